// File: doc/BRIEF.md
# Two-Level Translation Lookaside Buffer

This block caches virtual-to-physical page translations in two fully associative levels. The small first level has 12 entries and the larger second level has 24. A virtual page number presented on the request port is compared against every valid first-level entry at once. A first-level hit returns the physical frame number on the next cycle. On a first-level miss the block probes the second level in the following cycle. A second-level hit returns the frame and also copies the translation into the first level.

When both levels miss, the block asks an external page-table walker for the translation over a valid/ready request channel. When the walker answers, the block writes the returned frame into both levels and passes it back to the requester. Entries hold only the page number, so every translation belongs to the current process. The flush input is raised at each context switch or preemption point and empties both levels in one cycle.

The controller is a four-state machine. The states are:
- `ST_IDLE`: accepts a request and probes the first level.
- `ST_L2`: probes the second level.
- `ST_WREQ`: offers the walk request.
- `ST_WWAIT`: waits for the walker's response.

The transitions are:
- `ST_IDLE` stays in `ST_IDLE` on a first-level hit.
- `ST_IDLE` moves to `ST_L2` on a first-level miss.
- `ST_L2` returns to `ST_IDLE` on a second-level hit.
- `ST_L2` moves to `ST_WREQ` on a second-level miss.
- `ST_WREQ` moves to `ST_WWAIT` once the walker accepts the request.
- `ST_WWAIT` returns to `ST_IDLE` when the walker responds.

Top module: `two_level_tlb`

## Requirements
- R1: After reset, neither level holds a valid entry. `req_ready` is 1, while `resp_valid` and `walk_req_valid` are 0. The first lookup of any page therefore goes to the walker.
- R2: A request that hits the first level is accepted at a clock edge. `resp_valid` is 1 in the cycle after that edge, with the stored frame on `resp_pfn` and `resp_src` = 1. No walk request is made.
- R3: A request that misses the first level but hits the second raises `resp_valid` two cycles after acceptance, with `resp_src` = 2. The translation is also installed in the first level, so an immediate repeat lookup returns `resp_src` = 1.
- R4: On a double miss, `walk_req_valid` rises carrying the requested page on `walk_req_vpn`. Both stay unchanged until `walk_req_ready` is sampled high. The cycle after `walk_rsp_valid` is sampled high, `resp_valid` is 1 with `resp_pfn` equal to `walk_rsp_pfn` and `resp_src` = 3.
- R5: A translation returned by the walker is written into both levels. A repeat lookup hits the first level.
- R6: The first level holds 12 translations. When it is full, a new translation replaces the least recently used one, which can still hit in the second level.
- R7: The second level holds 24 translations with least-recently-used replacement. A page pushed out of both levels must be walked again.
- R8: A hit refreshes the entry's recency. After the first level is filled, re-touching its oldest entry makes the next fill evict the second-oldest entry instead.
- R9: A one-cycle pulse on `flush` invalidates every entry of both levels. A previously cached page then needs a walk.
- R10: If `flush` coincides with a walker response, the response is still returned to the requester. The flush wins over the fill, so neither level keeps that translation.
- R11: `req_ready` is 0 while a lookup is in progress, and 0 in any cycle where `flush` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries of both levels |
| req_valid | input | 1 | Lookup request present |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ready | output | 1 | Block accepts a lookup this cycle |
| resp_valid | output | 1 | One-cycle pulse: translation result present |
| resp_pfn | output | PFN_W | Physical frame number |
| resp_src | output | 2 | Where the result came from: 1 first level, 2 second level, 3 walker |
| walk_req_valid | output | 1 | Page-table walk requested |
| walk_req_vpn | output | VPN_W | Page to walk |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_rsp_valid | input | 1 | Walker returns a translation |
| walk_rsp_pfn | input | PFN_W | Frame returned by the walker |

## Verification
The hardest state to reach is a full first level whose least-recently-used order has been rearranged by hits. The bench first walks exactly 12 distinct pages. It then re-touches the oldest page and walks a thirteenth. This moves the victim, and the outcome is visible in `resp_src` when the re-touched page and its neighbour are looked up. A second hard case is a walker response and a flush landing in the same cycle. The bench plays the walker itself and raises `flush` on the exact cycle it drives `walk_rsp_valid`. A repeat lookup of that page then exposes whether the fill was dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int DEF_VPN_W      = 20;
    parameter int DEF_PFN_W      = 16;
    parameter int DEF_L1_ENTRIES = 12;
    parameter int DEF_L2_ENTRIES = 24;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_L2    = 2'd1,
        ST_WREQ  = 2'd2,
        ST_WWAIT = 2'd3
    } tlb_state_e;

    localparam logic [1:0] SRC_NONE = 2'd0;
    localparam logic [1:0] SRC_L1   = 2'd1;
    localparam logic [1:0] SRC_L2   = 2'd2;
    localparam logic [1:0] SRC_WALK = 2'd3;
endpackage

// File: rtl/tlb_level.sv
module tlb_level #(
    parameter int ENTRIES = 12,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   upd_idx;
    logic               upd_en;

    // Parallel tag compare, one comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    end

    always_comb begin
        lk_idx = '0;
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_idx = lk_idx | IDX_W'(i);
                lk_pfn = lk_pfn | pfn_q[i];
            end
        end
    end
    assign lk_hit = |match;

    // Victim: lowest invalid entry, else the oldest (age == ENTRIES-1)
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!vld_q[i] && !found) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
            end
        end
    end

    assign upd_en  = (fill_en || touch_en) && !flush;
    assign upd_idx = fill_en ? victim : touch_idx;

    // Valid bits and recency ages; ages always form a permutation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (flush) begin
            vld_q <= '0;
        end else if (upd_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == upd_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[upd_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
            if (fill_en) vld_q[victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[victim] <= fill_vpn;
            pfn_q[victim] <= fill_pfn;
        end
    end

    // R9: flush leaves no valid entry behind
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));
    // R10: a fill in the flush cycle is dropped
    a_r10_flush_beats_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fill_en) |=> !lk_hit);
    // R5: a page never sits in two entries of one level
    a_r5_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int VPN_W    = 20,
    parameter int PFN_W    = 16,
    parameter int L1_IDX_W = 4,
    parameter int L2_IDX_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                req_valid,
    input  logic [VPN_W-1:0]    req_vpn,
    output logic                req_ready,
    output logic                resp_valid,
    output logic [PFN_W-1:0]    resp_pfn,
    output logic [1:0]          resp_src,
    output logic                walk_req_valid,
    output logic [VPN_W-1:0]    walk_req_vpn,
    input  logic                walk_req_ready,
    input  logic                walk_rsp_valid,
    input  logic [PFN_W-1:0]    walk_rsp_pfn,
    output logic [VPN_W-1:0]    lk_vpn,
    input  logic                l1_hit,
    input  logic [L1_IDX_W-1:0] l1_idx,
    input  logic [PFN_W-1:0]    l1_pfn,
    input  logic                l2_hit,
    input  logic [L2_IDX_W-1:0] l2_idx,
    input  logic [PFN_W-1:0]    l2_pfn,
    output logic                l1_touch_en,
    output logic [L1_IDX_W-1:0] l1_touch_idx,
    output logic                l2_touch_en,
    output logic [L2_IDX_W-1:0] l2_touch_idx,
    output logic                l1_fill_en,
    output logic                l2_fill_en,
    output logic [VPN_W-1:0]    fill_vpn,
    output logic [PFN_W-1:0]    fill_pfn
);
    tlb_state_e       state, state_n;
    logic [VPN_W-1:0] vpn_q;
    logic             accept;
    logic             fire;
    logic [PFN_W-1:0] fire_pfn;
    logic [1:0]       fire_src;
    logic             l2_hit_ok;

    assign accept    = (state == ST_IDLE) && req_valid && !flush;
    assign l2_hit_ok = l2_hit && !flush;

    // State register plus latched page and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            vpn_q      <= '0;
            resp_valid <= 1'b0;
            resp_pfn   <= '0;
            resp_src   <= SRC_NONE;
        end else begin
            state      <= state_n;
            resp_valid <= fire;
            if (accept) vpn_q <= req_vpn;
            if (fire) begin
                resp_pfn <= fire_pfn;
                resp_src <= fire_src;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_n        = state;
        req_ready      = 1'b0;
        lk_vpn         = vpn_q;
        walk_req_valid = 1'b0;
        walk_req_vpn   = vpn_q;
        l1_touch_en    = 1'b0;
        l1_touch_idx   = l1_idx;
        l2_touch_en    = 1'b0;
        l2_touch_idx   = l2_idx;
        l1_fill_en     = 1'b0;
        l2_fill_en     = 1'b0;
        fill_vpn       = vpn_q;
        fill_pfn       = walk_rsp_pfn;
        fire           = 1'b0;
        fire_pfn       = l1_pfn;
        fire_src       = SRC_NONE;
        unique case (state)
            ST_IDLE: begin
                req_ready = !flush;
                lk_vpn    = req_vpn;
                if (accept) begin
                    if (l1_hit) begin
                        l1_touch_en = 1'b1;
                        fire        = 1'b1;
                        fire_pfn    = l1_pfn;
                        fire_src    = SRC_L1;
                    end else begin
                        state_n = ST_L2;
                    end
                end
            end
            ST_L2: begin
                if (l2_hit_ok) begin
                    l2_touch_en = 1'b1;
                    l1_fill_en  = 1'b1;
                    fill_pfn    = l2_pfn;
                    fire        = 1'b1;
                    fire_pfn    = l2_pfn;
                    fire_src    = SRC_L2;
                    state_n     = ST_IDLE;
                end else begin
                    state_n = ST_WREQ;
                end
            end
            ST_WREQ: begin
                walk_req_valid = 1'b1;
                if (walk_req_ready) state_n = ST_WWAIT;
            end
            ST_WWAIT: begin
                if (walk_rsp_valid) begin
                    l1_fill_en = 1'b1;
                    l2_fill_en = 1'b1;
                    fill_pfn   = walk_rsp_pfn;
                    fire       = 1'b1;
                    fire_pfn   = walk_rsp_pfn;
                    fire_src   = SRC_WALK;
                    state_n    = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // R2: first-level hit answers one cycle after acceptance
    a_r2_l1_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && !flush && l1_hit)
        |=> (resp_valid && resp_src == SRC_L1));
    // R3: second-level probe hit answers in the following cycle
    a_r3_l2_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_L2 && l2_hit && !flush)
        |=> (resp_valid && resp_src == SRC_L2));
    // R4: walk request held stable until accepted
    a_r4_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_req_ready)
        |=> (walk_req_valid && $stable(walk_req_vpn)));
    // R4: walker frame is forwarded unchanged
    a_r4_walk_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WWAIT && walk_rsp_valid)
        |=> (resp_valid && resp_src == SRC_WALK && resp_pfn == $past(walk_rsp_pfn)));
    // R11: no new request taken while a walk is outstanding
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready);
endmodule

// File: rtl/two_level_tlb.sv
module two_level_tlb
    import tlb_pkg::*;
#(
    parameter int VPN_W      = DEF_VPN_W,
    parameter int PFN_W      = DEF_PFN_W,
    parameter int L1_ENTRIES = DEF_L1_ENTRIES,
    parameter int L2_ENTRIES = DEF_L2_ENTRIES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [PFN_W-1:0] resp_pfn,
    output logic [1:0]       resp_src,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_req_ready,
    input  logic             walk_rsp_valid,
    input  logic [PFN_W-1:0] walk_rsp_pfn
);
    localparam int L1_IDX_W = $clog2(L1_ENTRIES);
    localparam int L2_IDX_W = $clog2(L2_ENTRIES);

    logic [VPN_W-1:0]    lk_vpn;
    logic                l1_hit, l2_hit;
    logic [L1_IDX_W-1:0] l1_idx, l1_touch_idx;
    logic [L2_IDX_W-1:0] l2_idx, l2_touch_idx;
    logic [PFN_W-1:0]    l1_pfn, l2_pfn, fill_pfn;
    logic                l1_touch_en, l2_touch_en, l1_fill_en, l2_fill_en;
    logic [VPN_W-1:0]    fill_vpn;

    tlb_ctrl #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_pfn(resp_pfn), .resp_src(resp_src),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_req_ready(walk_req_ready), .walk_rsp_valid(walk_rsp_valid),
        .walk_rsp_pfn(walk_rsp_pfn), .lk_vpn(lk_vpn),
        .l1_hit(l1_hit), .l1_idx(l1_idx), .l1_pfn(l1_pfn),
        .l2_hit(l2_hit), .l2_idx(l2_idx), .l2_pfn(l2_pfn),
        .l1_touch_en(l1_touch_en), .l1_touch_idx(l1_touch_idx),
        .l2_touch_en(l2_touch_en), .l2_touch_idx(l2_touch_idx),
        .l1_fill_en(l1_fill_en), .l2_fill_en(l2_fill_en),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
    );

    tlb_level #(.ENTRIES(L1_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_l1 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vpn(lk_vpn),
        .lk_hit(l1_hit), .lk_idx(l1_idx), .lk_pfn(l1_pfn),
        .touch_en(l1_touch_en), .touch_idx(l1_touch_idx),
        .fill_en(l1_fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
    );

    tlb_level #(.ENTRIES(L2_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_l2 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vpn(lk_vpn),
        .lk_hit(l2_hit), .lk_idx(l2_idx), .lk_pfn(l2_pfn),
        .touch_en(l2_touch_en), .touch_idx(l2_touch_idx),
        .fill_en(l2_fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
    );

    // R1: nothing is reported straight out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid && !walk_req_valid));
endmodule

// File: tb/tb_two_level_tlb.sv
module tb_two_level_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_vpn = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [15:0] resp_pfn;
    logic [1:0]  resp_src;
    logic        walk_req_valid;
    logic [19:0] walk_req_vpn;
    logic        walk_req_ready = 1'b0;
    logic        walk_rsp_valid = 1'b0;
    logic [15:0] walk_rsp_pfn = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    two_level_tlb dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_pfn(resp_pfn), .resp_src(resp_src),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_req_ready(walk_req_ready), .walk_rsp_valid(walk_rsp_valid),
        .walk_rsp_pfn(walk_rsp_pfn)
    );

    function automatic logic [15:0] frame_of(input logic [19:0] v);
        logic [19:0] t;
        t = v * 20'd3 + 20'd7;
        return t[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One lookup; the bench also plays the page-table walker
    task automatic lookup(input logic [19:0] v, input logic [1:0] exp_src,
                          input int rdy_dly, input bit flush_on_rsp, input string req);
        int  cyc = 0;
        bit  done = 1'b0;
        int  exp_cyc;
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn   = v;
        @(posedge clk);
        #1 req_valid = 1'b0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (resp_valid) begin
                done = 1'b1;
            end else if (walk_req_valid) begin
                chk(walk_req_vpn == v, "R4 walk page", int'(walk_req_vpn), int'(v));
                chk(!req_ready, "R11 busy", int'(req_ready), 0);
                for (int k = 0; k < rdy_dly; k++) begin
                    @(negedge clk);
                    chk(walk_req_valid && walk_req_vpn == v, "R4 hold",
                        int'(walk_req_valid), 1);
                end
                walk_req_ready = 1'b1;
                @(posedge clk);
                #1 walk_req_ready = 1'b0;
                @(negedge clk);
                @(negedge clk);
                walk_rsp_valid = 1'b1;
                walk_rsp_pfn   = frame_of(v);
                if (flush_on_rsp) flush = 1'b1;
                @(posedge clk);
                #1;
                walk_rsp_valid = 1'b0;
                flush = 1'b0;
                cyc = 0;
            end
        end
        exp_cyc = (exp_src == 2'd2) ? 2 : 1;
        chk(done, req, int'(done), 1);
        chk(resp_src == exp_src, req, int'(resp_src), int'(exp_src));
        chk(resp_pfn == frame_of(v), req, int'(resp_pfn), int'(frame_of(v)));
        chk(cyc == exp_cyc, req, cyc, exp_cyc);
        @(negedge clk);
        chk(!resp_valid, req, int'(resp_valid), 0);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        req_valid = 1'b1;
        #1 chk(!req_ready, "R11 flush cycle", int'(req_ready), 0);
        @(posedge clk);
        #1 flush = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready, "R1 ready", int'(req_ready), 1);
        chk(!resp_valid, "R1 resp", int'(resp_valid), 0);
        chk(!walk_req_valid, "R1 walk", int'(walk_req_valid), 0);
        lookup(20'h00100, 2'd3, 0, 1'b0, "R1 first lookup walks");
    endtask

    task automatic t_walk_fill();
        lookup(20'h00100, 2'd1, 0, 1'b0, "R2 R5 repeat hits first level");
        lookup(20'h00abc, 2'd3, 3, 1'b0, "R4 delayed walker ready");
        lookup(20'h00abc, 2'd1, 0, 1'b0, "R5 walked page in first level");
    endtask

    task automatic t_l1_capacity();
        do_flush();
        for (int i = 0; i < 13; i++) lookup(20'(i), 2'd3, 0, 1'b0, "R6 fill");
        lookup(20'd0, 2'd2, 0, 1'b0, "R6 R3 evicted from first level only");
        lookup(20'd0, 2'd1, 0, 1'b0, "R3 refilled into first level");
    endtask

    task automatic t_lru_touch();
        do_flush();
        for (int i = 0; i < 12; i++) lookup(20'(i + 32), 2'd3, 0, 1'b0, "R8 fill");
        lookup(20'd32, 2'd1, 0, 1'b0, "R8 touch oldest");
        lookup(20'd44, 2'd3, 0, 1'b0, "R8 extra fill");
        lookup(20'd32, 2'd1, 0, 1'b0, "R8 touched entry kept");
        lookup(20'd33, 2'd2, 0, 1'b0, "R8 second-oldest evicted");
    endtask

    task automatic t_l2_capacity();
        do_flush();
        for (int i = 0; i < 25; i++) lookup(20'(i + 64), 2'd3, 0, 1'b0, "R7 fill");
        lookup(20'd65, 2'd2, 0, 1'b0, "R7 second entry still in second level");
        lookup(20'd64, 2'd3, 0, 1'b0, "R7 oldest left both levels");
    endtask

    task automatic t_flush();
        lookup(20'h00333, 2'd3, 0, 1'b0, "R9 prime");
        lookup(20'h00333, 2'd1, 0, 1'b0, "R9 cached");
        do_flush();
        lookup(20'h00333, 2'd3, 0, 1'b0, "R9 flushed page walks");
        lookup(20'h00444, 2'd3, 1, 1'b1, "R10 response still returned");
        lookup(20'h00444, 2'd3, 0, 1'b0, "R10 fill dropped by flush");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_walk_fill();
        t_l1_capacity();
        t_lru_touch();
        t_l2_capacity();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule